// File: doc/BRIEF.md
# Buffered SPI Master

This block is a serial master that connects a plain register-style host port to a four-wire SPI bus. The host writes a byte into a single transmit holding slot. The shift engine takes the byte from that slot as soon as it is free and shifts it out on MOSI, most significant bit first. At the same moments it shifts in a byte from MISO. Received bytes land in a single receive slot that the host empties with a read strobe.

The bus timing is fixed as mode 0. The clock idles low. MOSI changes only together with a falling clock edge, and MISO is sampled on the rising edge. Chip select is active low. It stays asserted across consecutive bytes while the holding slot keeps being refilled, and it releases half a clock period after the last rising edge once nothing is pending. The clock runs at a fixed division of the system clock.

The block has three status levels: transmit slot empty, all transmission finished, and receive data waiting. Sticky event flags mirror these, together with a receive overrun event. The flags are cleared by write-one-to-clear. A single interrupt line is the OR of the flags the host has enabled.

Top module: `spi_master_buf`

## Requirements
- R1: While tx_enable is low the engine never starts a frame: cs_n stays high even when the transmit slot holds a byte, and the byte stays in the slot (tx_empty low).
- R2: Each frame carries 8 bits, MSB first, with one rising sclk edge per bit. MOSI holds steady while sclk is high, and MISO is sampled on each rising edge.
- R3: tx_empty drops when a byte is written and rises on the clock edge where that byte moves into the shift register. A write while the slot is full is discarded and never appears on MOSI.
- R4: tx_done is high only when the transmit slot is empty and no frame is in progress. It goes low as soon as a frame starts.
- R5: While rx_enable is low, completed frames are not accepted: rx_valid stays low and rd_data is unchanged.
- R6: rx_valid rises when a received byte is written to rd_data and falls on the cycle after a rd_strobe.
- R7: sclk is low whenever cs_n is high. The first rising edge of a transfer comes HALF_DIV system cycles after cs_n falls.
- R8: If the slot is loaded when a byte ends, the next byte follows with no gap. Consecutive rising edges stay 2*HALF_DIV cycles apart and cs_n stays low.
- R9: With nothing pending, cs_n rises HALF_DIV system cycles after the last rising sclk edge, in the same cycle that sclk falls.
- R10: irq_flags are sticky event bits: bit 0 = byte moved to shift register, bit 1 = all transmission finished, bit 2 = byte received, bit 3 = receive overrun. Writing a one to a bit of irq_clr clears that bit only. A set event wins over a clear in the same cycle.
- R11: irq is high exactly when some bit is set in both irq_flags and irq_en.
- R12: A byte received while rx_valid is still set, and not read in that cycle, replaces the old byte in rd_data and sets the overrun flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Allows the engine to start frames |
| rx_enable | input | 1 | Allows received bytes into the receive slot |
| wr_valid | input | 1 | Host write strobe for the transmit slot |
| wr_data | input | 8 | Byte to transmit |
| rd_strobe | input | 1 | Host read of the receive slot |
| rd_data | output | 8 | Receive slot contents |
| tx_empty | output | 1 | Transmit slot can take a byte |
| tx_done | output | 1 | Slot empty and no frame active |
| rx_valid | output | 1 | Unread byte in receive slot |
| irq_en | input | 4 | Per-flag interrupt enable |
| irq_clr | input | 4 | Write-one-to-clear for irq_flags |
| irq_flags | output | 4 | Sticky event flags |
| irq | output | 1 | Combined interrupt |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
The assertions check several invariants on every cycle: sclk stays low while deselected, MOSI holds while the clock is high, tx_done implies an empty slot, no frame starts while transmit is disabled, a read clears rx_valid, the receive slot ignores data while disabled, and flags stay set until cleared. Other properties depend on the actual sequence of bytes and can only be shown by the bench scenarios. These are the bit order on MOSI, the value captured from MISO, the cycle spacing of the first and last edges around chip select, the gapless chaining of two bytes under one chip select window, the overrun replacing the old byte, and the dropping of a write into a full slot.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CW = $clog2(BYTE_W);
    localparam int NFLAG  = 4;

    // event flag positions
    localparam int FLG_TAKE = 0;
    localparam int FLG_DONE = 1;
    localparam int FLG_RXV  = 2;
    localparam int FLG_OVR  = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic              active;
        logic              sclk;
        logic [BIT_CW-1:0] bitcnt;
        byte_t             txsh;
        byte_t             rxsh;
    } eng_state_t;

    typedef struct packed {
        logic  take;
        logic  finish;
        logic  rx_done;
        byte_t rx_byte;
    } eng_evt_t;

    function automatic byte_t shift_in(byte_t cur, logic b);
        return {cur[BYTE_W-2:0], b};
    endfunction

    function automatic logic is_last(logic [BIT_CW-1:0] cnt);
        return cnt == BIT_CW'(BYTE_W - 1);
    endfunction

endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     load_ok,
    input  byte_t    load_data,
    input  logic     miso,
    output logic     active,
    output logic     sclk,
    output logic     mosi,
    output logic     cs_n,
    output eng_evt_t evt
);
    eng_state_t st;
    logic       edge_fall;
    logic       edge_rise;
    logic       frame_end;

    assign edge_rise = st.active && tick && !st.sclk;
    assign edge_fall = st.active && tick && st.sclk;
    assign frame_end = edge_fall && is_last(st.bitcnt);

    assign active = st.active;
    assign sclk   = st.sclk;
    assign mosi   = st.txsh[BYTE_W-1];
    assign cs_n   = !st.active;

    always_comb begin
        evt.take    = load_ok && (!st.active || frame_end);
        evt.finish  = frame_end && !load_ok;
        evt.rx_done = edge_rise && is_last(st.bitcnt);
        evt.rx_byte = shift_in(st.rxsh, miso);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (!st.active) begin
            if (load_ok) begin
                st.active <= 1'b1;
                st.sclk   <= 1'b0;
                st.bitcnt <= '0;
                st.txsh   <= load_data;
            end
        end else if (edge_rise) begin
            st.sclk <= 1'b1;
            st.rxsh <= shift_in(st.rxsh, miso);
        end else if (edge_fall) begin
            st.sclk <= 1'b0;
            if (frame_end) begin
                if (load_ok) begin
                    st.txsh   <= load_data;
                    st.bitcnt <= '0;
                end else begin
                    st.active <= 1'b0;
                end
            end else begin
                st.txsh   <= st.txsh << 1;
                st.bitcnt <= st.bitcnt + 1'b1;
            end
        end
    end

    AST_B2B_HOLDS_CS: assert property (@(posedge clk) disable iff (rst)
        (evt.take && st.active) |=> st.active) else $error("cs released on chained byte"); // R8
    AST_FINISH_IDLES: assert property (@(posedge clk) disable iff (rst)
        evt.finish |=> (!st.active && !st.sclk)) else $error("engine still busy after finish"); // R9
endmodule

// File: rtl/spim_flags.sv
module spim_flags
    import spim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] clr,
    input  logic [NFLAG-1:0] en,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    assign irq = |(flags & en);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr) | set;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|(flags & ~clr)) |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)))
        else $error("flag dropped without clear"); // R10
    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set) |=> ((flags & $past(set)) == $past(set))) else $error("set event lost"); // R10
endmodule

// File: rtl/spi_master_buf.sv
module spi_master_buf
    import spim_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_enable,
    input  logic             rx_enable,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    input  logic             rd_strobe,
    output logic [7:0]       rd_data,
    output logic             tx_empty,
    output logic             tx_done,
    output logic             rx_valid,
    input  logic [3:0]       irq_en,
    input  logic [3:0]       irq_clr,
    output logic [3:0]       irq_flags,
    output logic             irq,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n
);
    logic     tick;
    logic     active;
    logic     tx_full;
    byte_t    tx_hold;
    byte_t    rx_hold;
    logic     rx_have;
    logic     load_ok;
    logic     wr_take;
    logic     rx_accept;
    logic     overrun;
    eng_evt_t evt;
    logic [NFLAG-1:0] flag_set;

    // transmit holding slot
    assign wr_take = wr_valid && !tx_full;
    assign load_ok = tx_full && tx_enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_full <= 1'b0;
            tx_hold <= '0;
        end else if (evt.take) begin
            tx_full <= 1'b0;
        end else if (wr_take) begin
            tx_full <= 1'b1;
            tx_hold <= wr_data;
        end
    end

    // receive slot
    assign rx_accept = evt.rx_done && rx_enable;
    assign overrun   = rx_accept && rx_have && !rd_strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_have <= 1'b0;
            rx_hold <= '0;
        end else if (rx_accept) begin
            rx_have <= 1'b1;
            rx_hold <= evt.rx_byte;
        end else if (rd_strobe) begin
            rx_have <= 1'b0;
        end
    end

    spim_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (active),
        .tick (tick)
    );

    spim_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load_ok   (load_ok),
        .load_data (tx_hold),
        .miso      (miso),
        .active    (active),
        .sclk      (sclk),
        .mosi      (mosi),
        .cs_n      (cs_n),
        .evt       (evt)
    );

    always_comb begin
        flag_set           = '0;
        flag_set[FLG_TAKE] = evt.take;
        flag_set[FLG_DONE] = evt.finish;
        flag_set[FLG_RXV]  = rx_accept;
        flag_set[FLG_OVR]  = overrun;
    end

    spim_flags u_flg (
        .clk   (clk),
        .rst   (rst),
        .set   (flag_set),
        .clr   (irq_clr),
        .en    (irq_en),
        .flags (irq_flags),
        .irq   (irq)
    );

    assign rd_data  = rx_hold;
    assign rx_valid = rx_have;
    assign tx_empty = !tx_full;
    assign tx_done  = !tx_full && !active;

    AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk) else $error("sclk high while deselected"); // R7
    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi)) else $error("mosi moved while sclk high"); // R2
    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !tx_enable) |=> cs_n) else $error("frame started while disabled"); // R1
    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> tx_empty) else $error("done with byte pending"); // R4
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !rx_accept) |=> !rx_valid) else $error("read did not clear valid"); // R6
    AST_RX_GATED: assert property (@(posedge clk) disable iff (rst)
        (!rx_enable && !rx_valid) |=> !rx_valid) else $error("byte accepted while rx off"); // R5
endmodule

// File: tb/tb_spi_master_buf.sv
`timescale 1ns/100ps
module tb_spi_master_buf;
    localparam int H = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_enable = 1'b0, rx_enable = 1'b0;
    logic       wr_valid = 1'b0, rd_strobe = 1'b0;
    logic [7:0] wr_data = '0;
    logic [3:0] irq_en = '0, irq_clr = '0;
    logic       miso = 1'b0;
    logic [7:0] rd_data;
    logic       tx_empty, tx_done, rx_valid, irq, sclk, mosi, cs_n;
    logic [3:0] irq_flags;

    always #2.5 clk = ~clk;

    spi_master_buf #(.HALF_DIV(H)) dut (
        .clk(clk), .rst(rst), .tx_enable(tx_enable), .rx_enable(rx_enable),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .tx_empty(tx_empty), .tx_done(tx_done),
        .rx_valid(rx_valid), .irq_en(irq_en), .irq_clr(irq_clr),
        .irq_flags(irq_flags), .irq(irq), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int cs_rises = 0;
    logic [7:0] exp_mosi[$];
    logic [7:0] slv_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: queue the expected MOSI byte and the slave reply, then write
    task automatic send(input logic [7:0] d, input logic [7:0] reply);
        exp_mosi.push_back(d);
        slv_q.push_back(reply);
        host_write(d);
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk); wr_valid = 1'b1; wr_data = d;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic clear_flags(input logic [3:0] m);
        @(negedge clk); irq_clr = m;
        @(negedge clk); irq_clr = '0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (!(tx_done && cs_n) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    // monitor and slave model, sampled away from the active edge
    initial begin
        logic       p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0, first = 1'b0;
        logic [7:0] mon = '0, sb = '0, exp;
        int         mbits = 0, sbits = 0, t_fall = 0, t_rise = 0;
        forever begin
            @(negedge clk);
            if (p_cs === 1'b1 && cs_n === 1'b0) begin
                t_fall = cyc; first = 1'b1; mbits = 0; sbits = 0;
                sb = (slv_q.size() > 0) ? slv_q.pop_front() : 8'h00;
                miso = sb[7];
            end
            if (p_sclk === 1'b1 && sclk === 1'b1)
                chk(mosi === p_mosi, "R2 mosi hold", mosi, p_mosi);
            if (p_sclk === 1'b0 && sclk === 1'b1) begin
                if (first) chk(cyc - t_fall == H, "R7 first edge", cyc - t_fall, H);
                else chk(cyc - t_rise == 2*H, "R8 edge spacing", cyc - t_rise, 2*H);
                first = 1'b0; t_rise = cyc;
                mon = {mon[6:0], mosi}; mbits++; sbits++;
                if (mbits == 8) begin
                    mbits = 0;
                    if (exp_mosi.size() == 0) chk(1'b0, "R3 unexpected byte", mon, 0);
                    else begin
                        exp = exp_mosi.pop_front();
                        chk(mon == exp, "R2 mosi byte", mon, exp);
                    end
                end
            end
            if (p_sclk === 1'b1 && sclk === 1'b0 && cs_n === 1'b0) begin
                if (sbits == 8) begin
                    sbits = 0;
                    sb = (slv_q.size() > 0) ? slv_q.pop_front() : 8'h00;
                end else sb = sb << 1;
                miso = sb[7];
            end
            if (p_cs === 1'b0 && cs_n === 1'b1) begin
                chk(cyc - t_rise == H, "R9 cs release", cyc - t_rise, H);
                cs_rises++;
            end
            p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
        end
    end

    initial begin
        int n0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1 && sclk == 0, "R7 reset bus idle", {cs_n, sclk}, 2'b10);
        chk(tx_empty && tx_done && !rx_valid, "R4 reset status", {tx_empty, tx_done, rx_valid}, 3'b110);
        chk(irq_flags == 0 && !irq, "R10 reset flags", irq_flags, 0);

        // transmit disabled: byte waits in the slot
        send(8'hA5, 8'h3C);
        repeat (40) @(negedge clk);
        chk(cs_n == 1, "R1 no start while disabled", cs_n, 1);
        chk(tx_empty == 0, "R1 byte held", tx_empty, 0);
        host_write(8'h11); // dropped, slot full
        @(negedge clk); tx_enable = 1'b1;
        @(negedge clk);
        chk(cs_n == 0, "R1 start after enable", cs_n, 0);
        chk(tx_empty == 1, "R3 empty on move", tx_empty, 1);
        chk(tx_done == 0, "R4 not done while active", tx_done, 0);
        wait_idle();
        chk(tx_done == 1, "R4 done after frame", tx_done, 1);
        chk(exp_mosi.size() == 0, "R3 dropped write", exp_mosi.size(), 0);
        chk(rx_valid == 0 && rd_data == 8'h00, "R5 rx disabled", rd_data, 0);
        chk(irq_flags == 4'b0011, "R10 tx events", irq_flags, 4'b0011);
        chk(irq == 0, "R11 masked", irq, 0);
        clear_flags(4'hF);
        @(negedge clk);
        chk(irq_flags == 0, "R10 w1c all", irq_flags, 0);

        // single byte with receive
        rx_enable = 1'b1; irq_en = 4'b0100;
        send(8'h81, 8'hC3);
        wait_idle();
        chk(rx_valid == 1, "R6 valid set", rx_valid, 1);
        chk(rd_data == 8'hC3, "R6 miso byte", rd_data, 8'hC3);
        chk(irq == 1, "R11 rx irq", irq, 1);
        chk(irq_flags == 4'b0111, "R10 rx flags", irq_flags, 4'b0111);
        host_read();
        chk(rx_valid == 0, "R6 read clears", rx_valid, 0);
        clear_flags(4'b0100);
        @(negedge clk);
        chk(irq_flags == 4'b0011, "R10 partial clear", irq_flags, 4'b0011);
        chk(irq == 0, "R11 cleared", irq, 0);
        clear_flags(4'hF);

        // two chained bytes, no read between: overrun
        irq_en = 4'b1000;
        n0 = cs_rises;
        send(8'hFF, 8'h5A);
        send(8'h00, 8'hA7);
        wait_idle();
        chk(cs_rises - n0 == 1, "R8 one cs window", cs_rises - n0, 1);
        chk(rd_data == 8'hA7, "R12 newest kept", rd_data, 8'hA7);
        chk(irq_flags[3] == 1, "R12 overrun flag", irq_flags[3], 1);
        chk(irq == 1, "R11 overrun irq", irq, 1);
        clear_flags(4'b1000);
        @(negedge clk);
        chk(irq_flags == 4'b0111 && irq == 0, "R10 clear overrun", irq_flags, 4'b0111);
        host_read();

        // done event drives irq
        clear_flags(4'hF);
        irq_en = 4'b0010;
        @(negedge clk);
        chk(irq == 0, "R11 idle", irq, 0);
        send(8'h6E, 8'h19);
        wait_idle();
        chk(irq == 1 && irq_flags[1], "R11 done irq", irq, 1);
        chk(rd_data == 8'h19, "R6 second read", rd_data, 8'h19);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule